// File: doc/BRIEF.md
# Signature-Marked Time-Shared FIR Filter

This block is a finite impulse response filter built around one multiplier and one accumulator that are reused for every tap. A fixed controller schedule walks the taps one per cycle for each accepted input sample, then presents the filtered result for a single cycle with a valid strobe raised. The schedule runs for NTAPS+3 cycles per sample, and only one of those cycles carries a result.

The output port is otherwise idle in the remaining cycles. The block fills a chosen subset of these free cycles with internal working values: the running sum, the latest product, a delay-line element or the newest sample. The valid strobe stays low in those cycles, so a consumer that honours the strobe sees a normal filter. An owner who knows the mark mask, the source table and the input stream can predict the words on the port and use them as a signature. The cost-less variant only steers values that already reach the output (sum and product). The low-cost variant adds output multiplexer inputs for the delay line and the newest sample.

Top module: `marked_fir`

## Requirements
- R1: A synchronous active-high reset clears the delay line, the accumulator, the product register, the output word and the valid flag, and returns the schedule to idle (slot 0).
- R2: A start pulse seen in idle begins a period of NTAPS+3 slots, numbered 0 (the accepting cycle) to NTAPS+2. The valid flag is high only for slot NTAPS+2. A new start is accepted in the idle cycle right after it.
- R3: The valid result is the low W bits of the full-precision sum over k of x[n-k]*c(k). Here x[n] is the newest sample, both terms are two's complement, and c(k) = ((7k+3) mod 19) - 9.
- R4: A start pulse while the schedule is not idle has no effect on the schedule, the delay line or the result.
- R5: Bit s of the mark mask (default 0x…5555, which marks slots 0, 2, 4, 6, 8) puts a source value on the output in free slot s with valid low. The bit for the result slot is ignored.
- R6: In a free slot whose mask bit is clear, the output keeps its previous value.
- R7: Slot s uses source code ((s>>1)+SEED) mod 4: 0 gives the accumulator, 1 the product register, 2 delay element (s mod NTAPS) with element 0 the newest, and 3 the newest sample, each taken as its low W bits. In slot 1 the accumulator and product are 0. In slot s from 2 to NTAPS+1 the product is p(s-2) = x[n-s+2]*c(s-2) and the accumulator is the sum of p(j) for j < s-2. In slot 0 both still hold their values from the end of the previous period: the full sum and p(NTAPS-1). Slot 0 sees the delay line before the new sample is shifted in.
- R8: In cost-less mode, source codes 2 and 3 are replaced by 0 and 1, so only the accumulator and product reach the output in free slots.
- R9: While idle with no start, the output word and the datapath stay constant and the valid flag stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Accept sample_i when the schedule is idle |
| sample_i | input | W | Two's-complement input sample |
| result_o | output | W | Filter result in the valid slot, signature or held word otherwise |
| valid_o | output | 1 | High in the single result slot of each period |

## Verification
The assertions take for granted that reset is held for at least two clock edges. This lets the history-based checks on the output multiplexer compare against datapath values that reset has already cleared. They also take for granted that the mark mask is no wider than 64 slots. The stimulus asserts reset for three cycles at the start and two cycles mid-run. It also raises start in the middle of a period, but clears it before the idle slot, so that only the intended samples enter the delay line.

// File: rtl/marked_fir_pkg.sv
package marked_fir_pkg;

    // Output source selector for signature slots
    typedef enum logic [1:0] {
        SRC_ACC  = 2'd0,
        SRC_PROD = 2'd1,
        SRC_TAP  = 2'd2,
        SRC_IN   = 2'd3
    } src_e;

    // Tap coefficient generator
    function automatic int coef_of(input int k);
        return ((7 * k + 3) % 19) - 9;
    endfunction

    // Source code chosen for slot s; cost-less mode folds onto acc/product
    function automatic src_e src_of(input int s, input int seed, input bit low_cost);
        int c;
        c = ((s >> 1) + seed) % 4;
        if (!low_cost) c = c & 1;
        return src_e'(c[1:0]);
    endfunction

endpackage

// File: rtl/marked_fir_ctrl.sv
module marked_fir_ctrl
    import marked_fir_pkg::*;
#(
    parameter int          NTAPS    = 8,
    parameter logic [63:0] MARK_EN  = 64'h5555_5555_5555_5555,
    parameter int          SEED     = 0,
    parameter bit          LOW_COST = 1'b0,
    localparam int         NST      = NTAPS + 3,
    localparam int         RES      = NST - 1,
    localparam int         STW      = $clog2(NST)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_i,
    output logic [STW-1:0] st_o,
    output logic           load_o,
    output logic           mark_o,
    output logic           res_o,
    output src_e           sel_o
);

    typedef struct packed {
        logic [STW-1:0] st;
    } ctrl_s;

    ctrl_s ctrl_d, ctrl_q;

    logic mark_tbl [NST];
    src_e src_tbl  [NST];

    // Per-slot mark table; the result slot is never marked
    for (genvar g = 0; g < NST; g++) begin : g_slot
        assign mark_tbl[g] = (g != RES) && MARK_EN[g];
        assign src_tbl[g]  = src_of(g, SEED, LOW_COST);
    end

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_q.st == '0) begin
            if (start_i) ctrl_d.st = STW'(1);
        end else if (ctrl_q.st == STW'(RES)) begin
            ctrl_d.st = '0;
        end else begin
            ctrl_d.st = ctrl_q.st + STW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

    assign st_o   = ctrl_q.st;
    assign load_o = (ctrl_q.st == '0) && start_i;
    assign res_o  = (ctrl_q.st == STW'(RES));
    assign mark_o = mark_tbl[ctrl_q.st];
    assign sel_o  = src_tbl[ctrl_q.st];

    // R4
    busy_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.st != '0 && ctrl_q.st != STW'(RES)) |=> ctrl_q.st == $past(ctrl_q.st) + STW'(1));

    // R2
    period_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.st == STW'(RES)) |=> ctrl_q.st == '0);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.st == '0 && !start_i) |=> ctrl_q.st == '0);

endmodule

// File: rtl/marked_fir_dp.sv
module marked_fir_dp
    import marked_fir_pkg::*;
#(
    parameter int  NTAPS = 8,
    parameter int  W     = 16,
    parameter int  CW    = 8,
    localparam int NST   = NTAPS + 3,
    localparam int STW   = $clog2(NST),
    localparam int KW    = $clog2(NTAPS),
    localparam int PW    = W + CW,
    localparam int ACCW  = PW + KW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load_i,
    input  logic [STW-1:0] st_i,
    input  logic [W-1:0]   sample_i,
    output logic [W-1:0]   acc_lo_o,
    output logic [W-1:0]   prod_lo_o,
    output logic [W-1:0]   tap_lo_o,
    output logic [W-1:0]   new_lo_o
);

    typedef struct packed {
        logic [NTAPS-1:0][W-1:0] taps;
        logic signed [ACCW-1:0]  acc;
        logic signed [PW-1:0]    prod;
    } dp_s;

    dp_s dp_d, dp_q;

    logic signed [CW-1:0] coef_tbl [NTAPS];

    for (genvar g = 0; g < NTAPS; g++) begin : g_coef
        assign coef_tbl[g] = CW'(coef_of(g));
    end

    logic [KW-1:0]        kidx;
    logic [KW-1:0]        tidx;
    logic signed [PW-1:0] xa_w;
    logic signed [PW-1:0] ca_w;

    assign kidx = KW'(st_i - STW'(1));
    assign tidx = KW'(int'(st_i) % NTAPS);
    assign xa_w = PW'($signed(dp_q.taps[kidx]));
    assign ca_w = PW'(coef_tbl[kidx]);

    always_comb begin
        dp_d = dp_q;
        if (load_i) begin
            dp_d.taps = {dp_q.taps[NTAPS-2:0], sample_i};
            dp_d.acc  = '0;
            dp_d.prod = '0;
        end else if (st_i >= STW'(1) && st_i <= STW'(NTAPS)) begin
            dp_d.prod = xa_w * ca_w;
            dp_d.acc  = dp_q.acc + ACCW'($signed(dp_q.prod));
        end else if (st_i == STW'(NTAPS + 1)) begin
            dp_d.acc  = dp_q.acc + ACCW'($signed(dp_q.prod));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) dp_q <= '0;
        else     dp_q <= dp_d;
    end

    assign acc_lo_o  = dp_q.acc[W-1:0];
    assign prod_lo_o = dp_q.prod[W-1:0];
    assign tap_lo_o  = dp_q.taps[tidx];
    assign new_lo_o  = dp_q.taps[0];

    // R9
    idle_dp_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (st_i == '0 && !load_i) |=> $stable(dp_q));

    // R7
    first_mac_clear_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (acc_lo_o == '0 && prod_lo_o == '0 && new_lo_o == $past(sample_i)));

endmodule

// File: rtl/marked_fir_outmux.sv
module marked_fir_outmux
    import marked_fir_pkg::*;
#(
    parameter int W        = 16,
    parameter bit LOW_COST = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         mark_i,
    input  logic         res_i,
    input  src_e         sel_i,
    input  logic [W-1:0] acc_lo_i,
    input  logic [W-1:0] prod_lo_i,
    input  logic [W-1:0] tap_lo_i,
    input  logic [W-1:0] new_lo_i,
    output logic [W-1:0] result_o,
    output logic         valid_o
);

    typedef struct packed {
        logic [W-1:0] word;
        logic         vld;
    } om_s;

    om_s om_d, om_q;
    logic [W-1:0] pick;

    if (LOW_COST) begin : g_low
        always_comb begin
            case (sel_i)
                SRC_ACC:  pick = acc_lo_i;
                SRC_PROD: pick = prod_lo_i;
                SRC_TAP:  pick = tap_lo_i;
                default:  pick = new_lo_i;
            endcase
        end
    end else begin : g_free
        logic unused_lc;
        assign unused_lc = ^{tap_lo_i, new_lo_i, sel_i[1]};
        assign pick = sel_i[0] ? prod_lo_i : acc_lo_i;

        // R8
        costless_src_chk: assert property (@(posedge clk) disable iff (rst)
            (!$stable(om_q.word) && !om_q.vld) |->
                (om_q.word == $past(acc_lo_i) || om_q.word == $past(prod_lo_i)));
    end

    always_comb begin
        om_d     = om_q;
        om_d.vld = 1'b0;
        if (res_i) begin
            om_d.word = acc_lo_i;
            om_d.vld  = 1'b1;
        end else if (mark_i) begin
            om_d.word = pick;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) om_q <= '0;
        else     om_q <= om_d;
    end

    assign result_o = om_q.word;
    assign valid_o  = om_q.vld;

    // R2
    single_valid_chk: assert property (@(posedge clk) disable iff (rst)
        om_q.vld |=> !om_q.vld);

    // R5
    valid_from_result_chk: assert property (@(posedge clk) disable iff (rst)
        om_q.vld |-> ($past(res_i) && om_q.word == $past(acc_lo_i)));

    // R6
    hold_unmarked_chk: assert property (@(posedge clk) disable iff (rst)
        (!mark_i && !res_i) |=> $stable(om_q.word));

endmodule

// File: rtl/marked_fir.sv
module marked_fir
    import marked_fir_pkg::*;
#(
    parameter int          NTAPS    = 8,
    parameter int          W        = 16,
    parameter int          CW       = 8,
    parameter logic [63:0] MARK_EN  = 64'h5555_5555_5555_5555,
    parameter int          SEED     = 0,
    parameter bit          LOW_COST = 1'b0,
    localparam int         NST      = NTAPS + 3,
    localparam int         STW      = $clog2(NST)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [W-1:0] sample_i,
    output logic [W-1:0] result_o,
    output logic         valid_o
);

    logic [STW-1:0] st;
    logic           load;
    logic           mark;
    logic           res;
    src_e           sel;
    logic [W-1:0]   acc_lo, prod_lo, tap_lo, new_lo;

    marked_fir_ctrl #(
        .NTAPS(NTAPS), .MARK_EN(MARK_EN), .SEED(SEED), .LOW_COST(LOW_COST)
    ) ctrl_i (
        .clk(clk), .rst(rst), .start_i(start_i),
        .st_o(st), .load_o(load), .mark_o(mark), .res_o(res), .sel_o(sel)
    );

    marked_fir_dp #(
        .NTAPS(NTAPS), .W(W), .CW(CW)
    ) dp_i (
        .clk(clk), .rst(rst), .load_i(load), .st_i(st), .sample_i(sample_i),
        .acc_lo_o(acc_lo), .prod_lo_o(prod_lo), .tap_lo_o(tap_lo), .new_lo_o(new_lo)
    );

    marked_fir_outmux #(
        .W(W), .LOW_COST(LOW_COST)
    ) om_i (
        .clk(clk), .rst(rst), .mark_i(mark), .res_i(res), .sel_i(sel),
        .acc_lo_i(acc_lo), .prod_lo_i(prod_lo), .tap_lo_i(tap_lo), .new_lo_i(new_lo),
        .result_o(result_o), .valid_o(valid_o)
    );

endmodule

// File: tb/marked_fir_tb.sv
module marked_fir_tb_top;

    localparam int          NTAPS   = 8;
    localparam int          W       = 16;
    localparam int          NST     = NTAPS + 3;
    localparam int          RES     = NST - 1;
    localparam logic [63:0] MARK_EN = 64'h5555_5555_5555_5555;
    localparam int          SEED    = 0;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [W-1:0] sample_i = '0;
    logic [W-1:0] res_cl, res_lc;
    logic         vld_cl, vld_lc;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    marked_fir #(.NTAPS(NTAPS), .W(W), .MARK_EN(MARK_EN), .SEED(SEED), .LOW_COST(1'b0)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .sample_i(sample_i),
        .result_o(res_cl), .valid_o(vld_cl));

    marked_fir #(.NTAPS(NTAPS), .W(W), .MARK_EN(MARK_EN), .SEED(SEED), .LOW_COST(1'b1)) dut_lc_i (
        .clk(clk), .rst(rst), .start_i(start_i), .sample_i(sample_i),
        .result_o(res_lc), .valid_o(vld_lc));

    // Behavioural model state
    longint       xh [NTAPS];
    longint       prev_sum   = 0;
    longint       prev_plast = 0;
    logic [W-1:0] hold_cl    = '0;
    logic [W-1:0] hold_lc    = '0;

    function automatic longint coef(input int k);
        return longint'(((7 * k + 3) % 19) - 9);
    endfunction

    function automatic int src_code(input int s, input bit lc);
        int c;
        c = ((s >> 1) + SEED) % 4;
        if (!lc) c = c & 1;
        return c;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic void model_clear();
        for (int i = 0; i < NTAPS; i++) xh[i] = 0;
        prev_sum   = 0;
        prev_plast = 0;
        hold_cl    = '0;
        hold_lc    = '0;
    endfunction

    // One full period; checks every slot on both variants (R2..R8)
    task automatic run_sample(input logic [W-1:0] d, input bit spurious);
        longint xo [NTAPS];
        longint xn [NTAPS];
        longint p  [NTAPS];
        longint sum;
        for (int i = 0; i < NTAPS; i++) xo[i] = xh[i];
        xn[0] = longint'($signed(d));
        for (int i = 1; i < NTAPS; i++) xn[i] = xo[i-1];
        sum = 0;
        for (int j = 0; j < NTAPS; j++) begin
            p[j] = xn[j] * coef(j);
            sum  = sum + p[j];
        end
        @(negedge clk);
        start_i  = 1'b1;
        sample_i = d;
        for (int s = 0; s < NST; s++) begin
            longint a_v, p_v, t_v, n_v;
            @(negedge clk);
            if (s == 0) start_i = 1'b0;
            if (spurious && s == 3) begin start_i = 1'b1; sample_i = ~d; end
            if (spurious && s == 5) start_i = 1'b0;
            if (s == 0) begin
                a_v = prev_sum; p_v = prev_plast; t_v = xo[0]; n_v = xo[0];
            end else if (s == 1) begin
                a_v = 0; p_v = 0; t_v = xn[s % NTAPS]; n_v = xn[0];
            end else if (s <= NTAPS + 1) begin
                a_v = 0;
                for (int j = 0; j < s - 2; j++) a_v = a_v + p[j];
                p_v = p[s-2]; t_v = xn[s % NTAPS]; n_v = xn[0];
            end else begin
                a_v = sum; p_v = p[NTAPS-1]; t_v = xn[s % NTAPS]; n_v = xn[0];
            end
            if (s == RES) begin
                hold_cl = W'(sum);
                hold_lc = W'(sum);
                chk("R3 result cost-less", res_cl, W'(sum));
                chk("R3 result low-cost", res_lc, W'(sum));
                chk_bit("R2 valid cost-less", vld_cl, 1'b1);
                chk_bit("R2 valid low-cost", vld_lc, 1'b1);
            end else begin
                if (MARK_EN[s]) begin
                    for (int v = 0; v < 2; v++) begin
                        longint val;
                        case (src_code(s, v == 1))
                            0: val = a_v;
                            1: val = p_v;
                            2: val = t_v;
                            default: val = n_v;
                        endcase
                        if (v == 1) hold_lc = W'(val);
                        else        hold_cl = W'(val);
                    end
                    chk("R5 R7 R8 mark cost-less", res_cl, hold_cl);
                    chk("R5 R7 mark low-cost", res_lc, hold_lc);
                end else begin
                    chk("R6 hold cost-less", res_cl, hold_cl);
                    chk("R6 hold low-cost", res_lc, hold_lc);
                end
                chk_bit("R2 free slot valid low cost-less", vld_cl, 1'b0);
                chk_bit("R2 free slot valid low low-cost", vld_lc, 1'b0);
            end
        end
        for (int i = 0; i < NTAPS; i++) xh[i] = xn[i];
        prev_sum   = sum;
        prev_plast = p[NTAPS-1];
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        chk("R1 reset word cost-less", res_cl, '0);
        chk("R1 reset word low-cost", res_lc, '0);
        chk_bit("R1 reset valid", vld_cl | vld_lc, 1'b0);
        rst = 1'b0;
        model_clear();
    endtask

    task automatic test_single();
        run_sample(16'h0123, 1'b0);
    endtask

    task automatic test_stream();
        for (int i = 0; i < 40; i++) run_sample(W'($urandom), 1'b0);
    endtask

    task automatic test_extremes();
        for (int i = 0; i < NTAPS; i++) run_sample(16'h7fff, 1'b0);
        for (int i = 0; i < NTAPS; i++) run_sample(16'h8000, 1'b0);
    endtask

    // R4: start raised mid-period must not add a sample
    task automatic test_spurious();
        run_sample(16'h1111, 1'b1);
        run_sample(16'h2222, 1'b0);
    endtask

    // R9: idle with no start keeps the port steady
    task automatic test_idle_wait();
        repeat (6) begin
            @(negedge clk);
            chk("R9 idle word cost-less", res_cl, hold_cl);
            chk("R9 idle word low-cost", res_lc, hold_lc);
            chk_bit("R9 idle valid", vld_cl | vld_lc, 1'b0);
        end
        run_sample(16'h0f0f, 1'b0);
    endtask

    // R1: reset in the middle of a period clears the delay line
    task automatic test_reset_midrun();
        @(negedge clk);
        start_i  = 1'b1;
        sample_i = 16'h4444;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 midrun reset word", res_cl | res_lc, '0);
        chk_bit("R1 midrun reset valid", vld_cl | vld_lc, 1'b0);
        rst = 1'b0;
        model_clear();
        run_sample(16'h0005, 1'b0);
        run_sample(16'hfffb, 1'b0);
    endtask

    initial begin
        #(200000 * 10);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        model_clear();
        test_reset();
        test_single();
        test_stream();
        test_extremes();
        test_spurious();
        test_idle_wait();
        test_reset_midrun();
        test_stream();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule